// File: doc/BRIEF.md
# Write Cycle Status Reporter

This block is the device-side read path of a byte-wide nonvolatile memory while a byte is being programmed. The host loads a byte by holding chip select and write strobe low together. The internal write cycle begins when the first of those two strobes returns high. For a programmable number of clocks after that, the device is busy. During that time the read bus does not show the array. It shows a status byte built from the byte that was just loaded.

Two bits of the status byte carry progress. Bit 7 reads as the inverse of the loaded byte's bit 7, so it only matches once the write has landed. Bit 6 flips on every read while the cycle runs, and it starts at 1. Once the timer expires, the byte is committed to a small register array and reads return stored data again. The block has no separate ready pin, so the host learns completion only through these two bits. The busy time is set by a length input, which lets a bench use short write cycles.

Top module: `wstat_top`

## Requirements
- R1: After reset the read bus is 0x00, and every array location reads 0x00.
- R2: A byte load is a clock on which `ce_n` and `we_n` are both sampled low. The address and data of the last such clock are captured. The write cycle starts on the first clock on which either strobe is sampled high after a load, whichever strobe rises first.
- R3: The device stays busy for `cyc_len` clocks after the start edge, and a value of 0 counts as 1. A read detected k clocks after the start edge returns status when k <= length and returns the stored byte when k > length.
- R4: While busy, a read at any address returns bit 7 equal to the inverse of the loaded byte's bit 7.
- R5: While busy, read bits 5..0 equal bits 5..0 of the loaded byte.
- R6: The first busy read after a start returns bit 6 = 1, and each later busy read returns the opposite of the one before.
- R7: The bit-6 flip-flop advances only once per rising edge of `rd_stb`. Holding `rd_stb` high for several clocks counts as one read.
- R8: When not busy, a read returns the byte stored at `rd_addr`, and repeated reads return the same bit 6.
- R9: Loads attempted while busy are ignored. They do not restart the cycle, do not change the status byte, and do not write the array.
- R10: `rd_data` changes only on the clock that detects a rising `rd_stb`, and it holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| ld_addr | input | ADDR_W | Address of the byte being loaded |
| ld_data | input | 8 | Byte being loaded |
| cyc_len | input | CNT_W | Write cycle length in clocks (0 treated as 1) |
| rd_stb | input | 1 | Read strobe; each rising edge is one read |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Registered read data or status byte |

## Verification
The bench varies which strobe ends a load: write strobe first, chip select first, or both together. All three must produce the same start edge. Busy reads use random addresses and random gaps between reads. This separates status reporting from array access and shows whether bit 6 follows reads rather than clocks. Directed cases place a read exactly at the last busy clock and at the first idle clock, and use a zero length. They also hold the read strobe high for several clocks and attempt a load while busy. These cases expose off-by-one timer ends, level-triggered toggling and restarts caused by stray loads.

// File: rtl/wstat_pkg.sv
package wstat_pkg;
  localparam int BYTE_W  = 8;
  localparam int INV_POS = 7;
  localparam int TOG_POS = 6;

  // status byte shown while a write cycle is running
  function automatic logic [BYTE_W-1:0] make_status(input logic [BYTE_W-1:0] d,
                                                    input logic              t);
    logic [BYTE_W-1:0] s;
    s          = d;
    s[INV_POS] = ~d[INV_POS];
    s[TOG_POS] = t;
    return s;
  endfunction
endpackage

// File: rtl/wstat_load_capture.sv
module wstat_load_capture #(
  parameter int ADDR_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ce_n,
  input  logic                       we_n,
  input  logic                       busy,
  input  logic [ADDR_W-1:0]          ld_addr,
  input  logic [wstat_pkg::BYTE_W-1:0] ld_data,
  output logic                       start_o,
  output logic [ADDR_W-1:0]          cap_addr_o,
  output logic [wstat_pkg::BYTE_W-1:0] cap_data_o
);
  localparam int DW = wstat_pkg::BYTE_W;

  logic          ld_now;
  logic          ld_q, ld_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d;
  logic          cap_en;

  // a load is only accepted while no write cycle is running
  assign ld_now = ~ce_n & ~we_n & ~busy;
  assign cap_en = ld_now;

  always_comb begin
    ld_d   = ld_now;
    addr_d = addr_q;
    data_d = data_q;
    if (cap_en) begin
      addr_d = ld_addr;
      data_d = ld_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      ld_q <= ld_d;
      if (cap_en) begin
        addr_q <= addr_d;
        data_q <= data_d;
      end
    end
  end

  // first strobe to rise after a load ends it
  assign start_o    = ld_q & ~ld_now & ~busy;
  assign cap_addr_o = addr_q;
  assign cap_data_o = data_q;
endmodule

// File: rtl/wstat_timer.sv
module wstat_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] cyc_len,
  output logic             busy_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] len_eff;
  logic             busy_q, busy_d;
  logic             done;
  logic             tick_en;

  assign len_eff = (cyc_len == '0) ? CNT_W'(1) : cyc_len;
  assign done    = busy_q && (cnt_q == CNT_W'(1));
  assign tick_en = start | busy_q;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = len_eff;
    end else if (busy_q) begin
      if (done) begin
        busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (tick_en) begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done;
endmodule

// File: rtl/wstat_array.sv
module wstat_array #(
  parameter int ADDR_W = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [wstat_pkg::BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]            rd_addr,
  output logic [wstat_pkg::BYTE_W-1:0] rd_data
);
  localparam int DW    = wstat_pkg::BYTE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0][DW-1:0] rows;

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    logic          row_en;
    logic [DW-1:0] row_q;
    assign row_en = wr_en && (wr_addr == ADDR_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        row_q <= '0;
      end else if (row_en) begin
        row_q <= wr_data;
      end
    end
    assign rows[i] = row_q;
  end

  assign rd_data = rows[rd_addr];
endmodule

// File: rtl/wstat_rdfmt.sv
module wstat_rdfmt (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd_stb,
  input  logic                         busy,
  input  logic                         start,
  input  logic [wstat_pkg::BYTE_W-1:0] arr_data,
  input  logic [wstat_pkg::BYTE_W-1:0] cap_data,
  output logic [wstat_pkg::BYTE_W-1:0] rd_data_o,
  output logic                         tog_o,
  output logic                         rd_edge_o
);
  import wstat_pkg::*;

  logic              stb_q;
  logic              rd_edge;
  logic              tog_q, tog_d, tog_en;
  logic [BYTE_W-1:0] out_q, out_d;

  assign rd_edge = rd_stb & ~stb_q;
  assign tog_en  = start | (rd_edge & busy);

  always_comb begin
    tog_d = tog_q;
    if (start) begin
      tog_d = 1'b1;
    end else if (rd_edge && busy) begin
      tog_d = ~tog_q;
    end
  end

  always_comb begin
    out_d = out_q;
    if (rd_edge) begin
      out_d = busy ? make_status(cap_data, tog_q) : arr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= 1'b0;
      tog_q <= 1'b1;
      out_q <= '0;
    end else begin
      stb_q <= rd_stb;
      if (tog_en) begin
        tog_q <= tog_d;
      end
      if (rd_edge) begin
        out_q <= out_d;
      end
    end
  end

  assign rd_data_o = out_q;
  assign tog_o     = tog_q;
  assign rd_edge_o = rd_edge;
endmodule

// File: rtl/wstat_top.sv
module wstat_top #(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [7:0]        ld_data,
  input  logic [CNT_W-1:0]  cyc_len,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int DW = wstat_pkg::BYTE_W;

  logic [1:0]        rs_q;
  logic              rst_sn;
  logic              start;
  logic              busy;
  logic              done;
  logic              tog;
  logic              rd_edge;
  logic [ADDR_W-1:0] cap_addr;
  logic [DW-1:0]     cap_data;
  logic [DW-1:0]     arr_data;

  // reset asserts at once, leaves on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= '0;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_sn = rs_q[1];

  wstat_load_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk        (clk),
    .rst_n      (rst_sn),
    .ce_n       (ce_n),
    .we_n       (we_n),
    .busy       (busy),
    .ld_addr    (ld_addr),
    .ld_data    (ld_data),
    .start_o    (start),
    .cap_addr_o (cap_addr),
    .cap_data_o (cap_data)
  );

  wstat_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_sn),
    .start   (start),
    .cyc_len (cyc_len),
    .busy_o  (busy),
    .done_o  (done)
  );

  wstat_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk     (clk),
    .rst_n   (rst_sn),
    .wr_en   (done),
    .wr_addr (cap_addr),
    .wr_data (cap_data),
    .rd_addr (rd_addr),
    .rd_data (arr_data)
  );

  wstat_rdfmt u_fmt (
    .clk       (clk),
    .rst_n     (rst_sn),
    .rd_stb    (rd_stb),
    .busy      (busy),
    .start     (start),
    .arr_data  (arr_data),
    .cap_data  (cap_data),
    .rd_data_o (rd_data),
    .tog_o     (tog),
    .rd_edge_o (rd_edge)
  );
endmodule

// File: rtl/wstat_chk.sv
module wstat_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             tog,
  input logic             rd_edge,
  input logic [CNT_W-1:0] cyc_len,
  input logic [7:0]       cap_data,
  input logic [7:0]       arr_data,
  input logic [7:0]       rd_data
);
  logic [CNT_W-1:0] len_c;
  logic [CNT_W-1:0] run_c;

  // busy length measured with counters, not a long delay
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_c <= '0;
      run_c <= '0;
    end else if (start) begin
      len_c <= (cyc_len == '0) ? CNT_W'(1) : cyc_len;
      run_c <= '0;
    end else if (busy) begin
      run_c <= run_c + CNT_W'(1);
    end
  end

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_c == len_c));

  p_status_msb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_edge && busy) |=> (rd_data[7] == ~$past(cap_data[7])));

  p_status_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_edge && busy) |=> (rd_data[5:0] == $past(cap_data[5:0])));

  p_tog_preset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> tog);

  p_tog_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!(rd_edge && busy) && !start) |=> $stable(tog));

  p_idle_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_edge && !busy) |=> (rd_data == $past(arr_data)));

  p_load_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cap_data));

  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_edge |=> $stable(rd_data));
endmodule

bind wstat_top wstat_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sn),
  .start    (start),
  .busy     (busy),
  .tog      (tog),
  .rd_edge  (rd_edge),
  .cyc_len  (cyc_len),
  .cap_data (cap_data),
  .arr_data (arr_data),
  .rd_data  (rd_data)
);

// File: tb/sim_wstat_top.sv
module sim_wstat_top;
  localparam int AW = 4;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ce_n;
  logic          we_n;
  logic [AW-1:0] ld_addr;
  logic [7:0]    ld_data;
  logic [CW-1:0] cyc_len;
  logic          rd_stb;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] shm [16];

  always #5 clk = ~clk;

  wstat_top #(.ADDR_W(AW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
    .ld_addr(ld_addr), .ld_data(ld_data), .cyc_len(cyc_len),
    .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [7:0] st_byte(input logic [7:0] d, input logic t);
    return {~d[7], t, d[5:0]};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge where the start edge follows
  task automatic do_load(input logic [AW-1:0] a, input logic [7:0] d, input int which);
    ce_n = 1'b0; we_n = 1'b0; ld_addr = a; ld_data = d;
    @(negedge clk);
    case (which)
      0: we_n = 1'b1;
      1: ce_n = 1'b1;
      default: begin we_n = 1'b1; ce_n = 1'b1; end
    endcase
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [7:0] v);
    rd_addr = a; rd_stb = 1'b1;
    @(negedge clk);
    v = rd_data;
    rd_stb = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] v, v1, v2;
    rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; ld_addr = '0; ld_data = '0;
    cyc_len = CW'(6); rd_stb = 1'b0; rd_addr = '0;
    for (int i = 0; i < 16; i++) shm[i] = 8'h00;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 bus", rd_data, 8'h00);
    do_read(4'd3, v);
    chk("R1 array", v, 8'h00);

    // R3 last busy clock (k = N) still shows status, write strobe first (R2)
    cyc_len = CW'(6);
    do_load(4'd2, 8'hA5, 0);
    repeat (6) @(negedge clk);
    do_read(4'd0, v);
    chk("R3 k=N status", v, st_byte(8'hA5, 1'b1));
    do_read(4'd2, v);
    chk("R3 stored", v, 8'hA5);
    shm[2] = 8'hA5;

    // R3 first idle clock (k = N+1), chip select first (R2)
    do_load(4'd4, 8'h3C, 1);
    repeat (7) @(negedge clk);
    do_read(4'd4, v);
    chk("R2 R3 k=N+1 data", v, 8'h3C);
    shm[4] = 8'h3C;

    // R3 zero length behaves as one clock
    cyc_len = '0;
    do_load(4'd5, 8'h81, 2);
    @(negedge clk);
    do_read(4'd5, v);
    chk("R3 len0 status", v, st_byte(8'h81, 1'b1));
    do_read(4'd5, v);
    chk("R3 len0 data", v, 8'h81);
    shm[5] = 8'h81;

    // R7 held strobe, R10 hold, R9 load while busy
    cyc_len = CW'(40);
    do_load(4'd7, 8'h5A, 0);
    @(negedge clk);
    rd_addr = 4'd1; rd_stb = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7 held first", rd_data, st_byte(8'h5A, 1'b1));
    rd_stb = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 hold", rd_data, st_byte(8'h5A, 1'b1));
    do_read(4'd1, v);
    chk("R7 one advance", v, st_byte(8'h5A, 1'b0));
    do_load(4'd9, 8'hFF, 0);
    @(negedge clk);
    do_read(4'd9, v);
    chk("R9 status kept", v, st_byte(8'h5A, 1'b1));
    repeat (45) @(negedge clk);
    shm[7] = 8'h5A;
    do_read(4'd7, v);
    chk("R9 old write", v, 8'h5A);
    do_read(4'd9, v);
    chk("R9 no write", v, shm[9]);

    // random phase
    for (int it = 0; it < 40; it++) begin
      logic [AW-1:0] a, b;
      logic [7:0]    d;
      logic          t;
      int            n, r, w;
      a = AW'($urandom % 16);
      d = 8'($urandom);
      n = 30 + int'($urandom % 31);
      w = int'($urandom % 3);
      cyc_len = CW'(n);
      do_load(a, d, w);
      @(negedge clk);
      t = 1'b1;
      r = 1 + int'($urandom % 5);
      for (int j = 0; j < r; j++) begin
        do_read(AW'($urandom % 16), v);
        chk("R4 inverted msb", {7'b0, v[7]}, {7'b0, ~d[7]});
        chk("R5 low bits", {2'b0, v[5:0]}, {2'b0, d[5:0]});
        chk("R6 toggle", {7'b0, v[6]}, {7'b0, t});
        t = ~t;
        repeat (int'($urandom % 4)) @(negedge clk);
      end
      repeat (n + 2) @(negedge clk);
      shm[a] = d;
      do_read(a, v1);
      chk("R8 stored", v1, shm[a]);
      do_read(a, v2);
      chk("R8 no toggle", v2, v1);
      b = AW'($urandom % 16);
      do_read(b, v);
      chk("R8 other addr", v, shm[b]);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule